// File: doc/BRIEF.md
# Sign-Bit Digital Output Selector

This block drives the single-bit digital output of a direct digital synthesizer. Depending on four configuration bits, the pin carries the most significant bit of the oscillator phase, a half-rate square wave derived from that bit, or the result of an external comparator. When the output is not enabled the pin's driver is released (output enable low), so a pad cell can tristate it.

The half-rate wave comes from a toggle register that flips on each rising edge of the phase MSB. The edge is found synchronously in the master clock domain. The comparator result arrives from an analog block with no timing relation to the master clock, so it passes through a synchronizer before it reaches the selector. Two configuration combinations are reserved. When either one is applied, the pin is driven low with its enable asserted, and a sticky error flag is raised that only reset clears.

All outputs are registered. Reset is synchronous and active low.

Top module: `sign_out_select`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pin_data`, `pin_oe` and `cfg_err` are 0 after that edge, and the half-rate toggle is cleared to 0.
- R2: With `out_en`=0 at an edge, `pin_oe` and `pin_data` are 0 after that edge, whatever the other configuration bits and data inputs are.
- R3: With `out_en`=1, `tri_mode`=0, `cmp_route`=0, `msb_full`=1, `pin_data` after an edge equals `phase_msb` sampled at that edge, and `pin_oe` is 1.
- R4: With `out_en`=1, `tri_mode`=0, `cmp_route`=0, `msb_full`=0, `pin_oe` is 1 and `pin_data` shows the half-rate toggle. The toggle flips at each edge where `phase_msb` is sampled 1 after being sampled 0 at the previous edge, and it stays unchanged otherwise, including while `phase_msb` is held high. `pin_data` reflects a flip one edge after the edge that made it.
- R5: The half-rate toggle keeps running while another source or no source is selected, so switching into half-rate mode shows its current state.
- R6: With `out_en`=1, `tri_mode`=0, `cmp_route`=1, `msb_full`=1, `pin_oe` is 1 and `cmp_in` sampled at edge e appears on `pin_data` after edge e+2.
- R7: With `out_en`=1 and either `tri_mode`=1, or `cmp_route`=1 with `msb_full`=0, the combination is reserved. After that edge `pin_data` is 0, `pin_oe` is 1 and `cfg_err` is 1.
- R8: Once set, `cfg_err` stays 1 when a legal combination follows, and only reset clears it.
- R9: With `out_en`=0, `tri_mode`=1 or `cmp_route`=1 with `msb_full`=0 is not reserved and does not set `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_msb | input | 1 | MSB of the oscillator phase |
| cmp_in | input | 1 | Asynchronous comparator result |
| out_en | input | 1 | Enables the pin driver |
| cmp_route | input | 1 | Selects the comparator instead of the phase bit |
| msb_full | input | 1 | 1 selects the full-rate MSB (or the comparator), 0 the half-rate wave |
| tri_mode | input | 1 | Triangle waveform mode of the DAC path; makes any enabled output reserved |
| pin_data | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable |
| cfg_err | output | 1 | Sticky reserved-combination flag |

## Verification
The bench holds `phase_msb` high for several cycles to catch a toggle that follows the level instead of the edge; such a design would oscillate on every clock. It runs phase edges while direct mode is selected and then switches to half-rate. A divider gated by the selection would then come up in the wrong phase. Comparator data is checked at its exact three-edge latency, which exposes a missing or extra synchronizer stage. Reserved combinations are applied while disabled, where a flag raised at that point would be wrong, and while enabled, followed by legal settings, where a flag that is not sticky would fall.

// File: rtl/sbo_pkg.sv
// Shared types for the sign-bit output selector.
package sbo_pkg;
    typedef enum logic [2:0] {
        RT_OFF  = 3'd0,
        RT_MSB  = 3'd1,
        RT_HALF = 3'd2,
        RT_CMP  = 3'd3,
        RT_BAD  = 3'd4
    } route_t;
endpackage

// File: rtl/sbo_sync.sv
// Multi-stage synchronizer for an asynchronous single-bit input.
// Assumes STAGES >= 2; all stages clear to 0 on reset.
module sbo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    genvar g;
    generate
        for (g = 0; g <= LAST; g++) begin : g_stage
            // Shift one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[g] <= 1'b0;
                else if (g == 0)
                    chain[g] <= d_async;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign d_sync = chain[LAST];
endmodule

// File: rtl/sbo_halver.sv
// Half-rate square wave from the phase MSB: toggles on each sampled rising
// edge. Assumes phase_msb is synchronous to clk.
module sbo_halver (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_msb,
    output logic half_q
);
    logic msb_q;
    logic rise;

    // Rising edge = sampled 1 now, 0 at the previous edge.
    always_comb rise = phase_msb & ~msb_q;

    // Track the previous MSB and flip the toggle on each rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_q  <= 1'b0;
            half_q <= 1'b0;
        end else begin
            msb_q  <= phase_msb;
            half_q <= half_q ^ rise;
        end
    end

    // R4
    halver_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_msb && !msb_q) |=> (half_q != $past(half_q)));
    // R4
    halver_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_msb && !msb_q) |=> $stable(half_q));
endmodule

// File: rtl/sbo_decode.sv
// Decodes the four configuration bits into a pin source.
// Disable wins over everything; triangle mode makes any enabled output reserved.
module sbo_decode
    import sbo_pkg::*;
(
    input  logic   out_en,
    input  logic   cmp_route,
    input  logic   msb_full,
    input  logic   tri_mode,
    output route_t route
);
    // Priority decode of the source.
    always_comb begin
        if (!out_en)
            route = RT_OFF;
        else if (tri_mode)
            route = RT_BAD;
        else if (cmp_route)
            route = msb_full ? RT_CMP : RT_BAD;
        else
            route = msb_full ? RT_MSB : RT_HALF;
    end
endmodule

// File: rtl/sign_out_select.sv
// Sign-bit output selector: registers the pin data and enable from the
// decoded source and holds a sticky flag for reserved settings.
// Assumes phase_msb is synchronous to clk and cmp_in is asynchronous.
module sign_out_select
    import sbo_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_msb,
    input  logic cmp_in,
    input  logic out_en,
    input  logic cmp_route,
    input  logic msb_full,
    input  logic tri_mode,
    output logic pin_data,
    output logic pin_oe,
    output logic cfg_err
);
    route_t route;
    logic   half_q;
    logic   cmp_s;
    logic   nxt_data;
    logic   nxt_oe;

    sbo_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(cmp_in), .d_sync(cmp_s)
    );

    sbo_halver u_half (
        .clk(clk), .rst_n(rst_n), .phase_msb(phase_msb), .half_q(half_q)
    );

    sbo_decode u_dec (
        .out_en(out_en), .cmp_route(cmp_route), .msb_full(msb_full),
        .tri_mode(tri_mode), .route(route)
    );

    // Select the next pin value from the decoded source.
    always_comb begin
        nxt_oe = 1'b1;
        case (route)
            RT_MSB:  nxt_data = phase_msb;
            RT_HALF: nxt_data = half_q;
            RT_CMP:  nxt_data = cmp_s;
            RT_BAD:  nxt_data = 1'b0;
            default: begin
                nxt_data = 1'b0;
                nxt_oe   = 1'b0;
            end
        endcase
    end

    // Register pin outputs and accumulate the reserved-setting flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_data <= 1'b0;
            pin_oe   <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            pin_data <= nxt_data;
            pin_oe   <= nxt_oe;
            cfg_err  <= cfg_err | (route == RT_BAD);
        end
    end

    // R2
    off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (!pin_oe && !pin_data));
    // R7
    reserved_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && (tri_mode || (cmp_route && !msb_full)))
        |=> (pin_oe && !pin_data && cfg_err));
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
    // R3
    direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && !tri_mode && !cmp_route && msb_full)
        |=> (pin_data == $past(phase_msb)));
endmodule

// File: tb/tb_sign_out_select.sv
module tb_sign_out_select;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phase_msb = 1'b0, cmp_in = 1'b0, out_en = 1'b0;
    logic cmp_route = 1'b0, msb_full = 1'b0, tri_mode = 1'b0;
    logic pin_data, pin_oe, cfg_err;

    always #2 clk = ~clk;

    sign_out_select dut (
        .clk(clk), .rst_n(rst_n), .phase_msb(phase_msb), .cmp_in(cmp_in),
        .out_en(out_en), .cmp_route(cmp_route), .msb_full(msb_full),
        .tri_mode(tri_mode), .pin_data(pin_data), .pin_oe(pin_oe),
        .cfg_err(cfg_err)
    );

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";
    logic [2:0] q_exp[$];
    string      q_tag[$];

    // Reference state written from the requirements.
    logic m_prev = 0, m_half = 0, m_s1 = 0, m_s2 = 0;
    logic m_data = 0, m_oe = 0, m_err = 0;

    task automatic step(input logic rst, input logic msb, input logic cmp,
                        input logic en, input logic cr, input logic full,
                        input logic tri_m);
        logic rise, bad;
        @(negedge clk);
        rst_n = rst; phase_msb = msb; cmp_in = cmp; out_en = en;
        cmp_route = cr; msb_full = full; tri_mode = tri_m;
        @(posedge clk);
        if (!rst) begin
            {m_prev, m_half, m_s1, m_s2, m_data, m_oe, m_err} = '0;
        end else begin
            rise = msb & ~m_prev;
            bad  = en & (tri_m | (cr & ~full));
            m_oe = en;
            if (!en || bad)     m_data = 1'b0;
            else if (cr)        m_data = m_s2;
            else if (full)      m_data = msb;
            else                m_data = m_half;
            m_err  = m_err | bad;
            m_half = m_half ^ rise;
            m_prev = msb;
            m_s2   = m_s1;
            m_s1   = cmp;
        end
        q_exp.push_back({m_data, m_oe, m_err});
        q_tag.push_back(cur_req);
    endtask

    // Monitor: compare outputs against expected items away from the edge.
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [2:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_chk++;
            if ({pin_data, pin_oe, cfg_err} !== e) begin
                n_fail++;
                $display("FAIL %s: {data,oe,err} actual=%b expected=%b",
                         t, {pin_data, pin_oe, cfg_err}, e);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) step(0, 1, 1, 1, 0, 1, 0);
        // R2: disabled, data inputs toggling
        cur_req = "R2";
        for (int i = 0; i < 6; i++) step(1, i[0], ~i[0], 0, i[1], 1, 0);
        // R9: reserved-looking settings while disabled
        cur_req = "R9";
        step(1, 0, 1, 0, 0, 1, 1);
        step(1, 1, 0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 1, 0, 1);
        // R3: direct MSB
        cur_req = "R3";
        step(1, 1, 0, 1, 0, 1, 0); step(1, 0, 0, 1, 0, 1, 0);
        step(1, 1, 0, 1, 0, 1, 0); step(1, 1, 0, 1, 0, 1, 0);
        step(1, 0, 0, 1, 0, 1, 0); step(1, 1, 0, 1, 0, 1, 0);
        // R4: half rate, square MSB then MSB held high
        cur_req = "R4";
        for (int i = 0; i < 12; i++) step(1, (i % 4) < 2, 0, 1, 0, 0, 0);
        for (int i = 0; i < 6; i++) step(1, 1, 0, 1, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0); step(1, 1, 0, 1, 0, 0, 0);
        step(1, 1, 0, 1, 0, 0, 0);
        // R5: edges while another source is shown, then switch to half rate
        cur_req = "R5";
        step(1, 0, 0, 1, 0, 1, 0); step(1, 1, 0, 1, 0, 1, 0);
        step(1, 0, 0, 0, 0, 1, 0); step(1, 1, 0, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0, 1, 0); step(1, 1, 0, 1, 0, 1, 0);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 0, 0, 0);
        // R6: comparator through the synchronizer
        cur_req = "R6";
        step(1, 0, 1, 1, 1, 1, 0); step(1, 0, 0, 1, 1, 1, 0);
        step(1, 0, 0, 1, 1, 1, 0); step(1, 1, 1, 1, 1, 1, 0);
        step(1, 0, 1, 1, 1, 1, 0); step(1, 0, 0, 1, 1, 1, 0);
        step(1, 0, 1, 1, 1, 1, 0); step(1, 0, 0, 1, 1, 1, 0);
        step(1, 0, 0, 1, 1, 1, 0);
        // R7: both reserved forms
        cur_req = "R7";
        step(1, 1, 1, 1, 1, 0, 0); step(1, 0, 1, 1, 1, 0, 0);
        step(1, 1, 1, 1, 0, 1, 1); step(1, 1, 0, 1, 0, 0, 1);
        // R8: flag stays through legal settings, clears on reset
        cur_req = "R8";
        step(1, 1, 0, 1, 0, 1, 0); step(1, 0, 0, 1, 0, 1, 0);
        step(1, 0, 0, 0, 0, 0, 0); step(1, 1, 1, 1, 1, 1, 0);
        step(0, 0, 0, 1, 0, 1, 0);
        step(1, 1, 0, 1, 0, 1, 0); step(1, 0, 0, 1, 0, 1, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule